// File: doc/BRIEF.md
# Host Interrupt Status Controller

This block holds the interrupt status and interrupt enable state of a host controller and produces the single interrupt request toward the host. Event logic elsewhere in the controller sends one-cycle pulses on a 32-bit event vector. Each pulse sets the status bit at the same position. Software reads the status word and writes ones to clear the bits it has handled. The interrupt sources are scheduling overrun, done-head writeback, start of frame, resume detected, unrecoverable error, frame number overflow, root hub status change and ownership change.

Enabling uses two addresses. A write of ones to the enable address sets enable bits. A write of ones to the disable address clears them. Bit 31 of the enable word is the master switch. The registered interrupt output is high when the master switch is on and at least one status bit in positions 0 to 30 is set together with its enable bit. The resume bit is set by a rising edge on the resume signal line. While the writeback-done bit is set, the writeback logic is told to hold off further head updates. A parameter removes the ownership-change source when the controller has no system-management interrupt pin.

Top module: `hc_irq_ctrl`

## Requirements
- R1: After reset, the status word and the enable word read 0 and irq_o is 0.
- R2: A pulse on evt_i sets the status bit at the same position, and the bit reads back after the next clock edge. Only positions 0, 1, 2, 4, 5, 6 and 30 respond. evt_i bit 3 and every other position have no effect.
- R3: A write to address 0 (status) clears each status bit written as 1 and leaves each bit written as 0 unchanged. Software can never set a status bit through this write.
- R4: Status bits never clear on their own. If an event pulse and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R5: A write to address 1 (enable) sets each enable bit written as 1 and leaves each bit written as 0 unchanged, so a 0 written to the master bit 31 is ignored. Only positions 0 to 6, 30 and 31 can be set. A read of address 1 returns the enable word.
- R6: A write to address 2 (disable) clears each enable bit written as 1, including the master bit. A read of address 2 returns the enable word. Address 3 reads 0 and ignores writes.
- R7: irq_o is a register. One cycle after the status and enable words change, it equals (enable bit 31) AND (any of bits 0 to 30 set in both status and enable).
- R8: Status bit 3 (resume) is set only when resume_sig_i goes from 0 to 1. Holding the line high does not set the bit again after software clears it.
- R9: wb_block_o is 1 exactly while status bit 1 (writeback done) is set.
- R10: With HAS_SMI = 0, status bit 30 always reads 0, even after an event pulse at position 30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select: 0 status, 1 enable, 2 disable, 3 none |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| evt_i | input | 32 | Event set pulses, one per status bit position |
| resume_sig_i | input | 1 | Resume signalling seen on the bus (level) |
| irq_o | output | 1 | Registered interrupt request |
| wb_block_o | output | 1 | Hold off done-head writeback |

## Verification
The main sweep covers every implemented source position, including resume, which is driven by an edge on its line. Each position is tried with its enable off and on and with the master off and on. The interrupt is then checked against the AND of the two enables, which separates a missing per-bit mask from a missing master gate. Other patterns check that written zeros change nothing, that ones on the unimplemented positions and on event bit 3 are dropped, and that a set and a clear in the same cycle leave the bit set. A second instance built without the ownership source checks that bit 30 stays tied off.

// File: rtl/hc_irq_pkg.sv
package hc_irq_pkg;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned WB_BIT     = 1;
  localparam int unsigned RESUME_BIT = 3;
  localparam int unsigned OWN_BIT    = 30;
  localparam int unsigned MASTER_BIT = 31;
  // event-capable status positions
  localparam logic [REG_W-1:0] SRC_MASK = 32'h4000_007F;

  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_EN   = 2'd1,
    SEL_DIS  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/hc_irq_resume_det.sv
module hc_irq_resume_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic rise_o
);
  logic line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_q <= 1'b0;
    else         line_q <= line_i;
  end

  assign rise_o = line_i & ~line_q;

  a_r8_single_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/hc_irq_status.sv
module hc_irq_status #(
  parameter int unsigned W       = hc_irq_pkg::REG_W,
  parameter bit          HAS_SMI = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  localparam logic [W-1:0] OWN_ONE  = W'(1) << hc_irq_pkg::OWN_BIT;
  localparam logic [W-1:0] IMPL     = HAS_SMI ? W'(hc_irq_pkg::SRC_MASK)
                                              : (W'(hc_irq_pkg::SRC_MASK) & ~OWN_ONE);

  logic [W-1:0] stat_q, stat_d;

  // set has priority so no event is lost
  assign stat_d = ((stat_q & ~clr_i) | set_i) & IMPL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_d;
  end

  assign stat_o = stat_q;

  a_r3_clear_applies: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~set_i) != '0) |=> ((stat_q & $past(clr_i & ~set_i)) == '0));

  a_r4_no_self_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(stat_q) & ~$past(clr_i) & ~stat_q) == '0));

  a_r4_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((set_i & IMPL) != '0) |=> ((stat_q & $past(set_i & IMPL)) == $past(set_i & IMPL)));
endmodule

// File: rtl/hc_irq_enable.sv
module hc_irq_enable #(
  parameter int unsigned W = hc_irq_pkg::REG_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] en_o
);
  localparam logic [W-1:0] EN_MASK = W'(hc_irq_pkg::SRC_MASK)
                                   | (W'(1) << hc_irq_pkg::MASTER_BIT);

  logic [W-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= ((en_q | set_i) & ~clr_i) & EN_MASK;
  end

  assign en_o = en_q;

  a_r5_master_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q[hc_irq_pkg::MASTER_BIT] && !clr_i[hc_irq_pkg::MASTER_BIT])
      |=> en_q[hc_irq_pkg::MASTER_BIT]);

  a_r6_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i != '0) |=> ((en_q & $past(clr_i)) == '0));
endmodule

// File: rtl/hc_irq_ctrl.sv
module hc_irq_ctrl #(
  parameter bit HAS_SMI = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [1:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic [31:0] evt_i,
  input  logic        resume_sig_i,
  output logic        irq_o,
  output logic        wb_block_o
);
  import hc_irq_pkg::*;
  localparam int unsigned W = REG_W;
  localparam logic [W-1:0] RES_ONE = W'(1) << RESUME_BIT;

  logic [W-1:0] stat, en, stat_set, stat_clr, en_set, en_clr;
  logic         resume_rise, irq_d, irq_q;
  reg_sel_e     sel;

  assign sel = reg_sel_e'(addr_i);

  hc_irq_resume_det u_resume (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (resume_sig_i),
    .rise_o (resume_rise)
  );

  // bit 3 comes only from the line edge
  assign stat_set = (evt_i & ~RES_ONE) | (resume_rise ? RES_ONE : '0);
  assign stat_clr = (wr_en_i && sel == SEL_STAT) ? wdata_i : '0;
  assign en_set   = (wr_en_i && sel == SEL_EN)   ? wdata_i : '0;
  assign en_clr   = (wr_en_i && sel == SEL_DIS)  ? wdata_i : '0;

  hc_irq_status #(.W(W), .HAS_SMI(HAS_SMI)) u_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (stat_set),
    .clr_i  (stat_clr),
    .stat_o (stat)
  );

  hc_irq_enable #(.W(W)) u_enable (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (en_set),
    .clr_i  (en_clr),
    .en_o   (en)
  );

  assign irq_d = en[MASTER_BIT] & (|(stat[W-2:0] & en[W-2:0]));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= irq_d;
  end

  always_comb begin
    unique case (sel)
      SEL_STAT: rdata_o = stat;
      SEL_EN,
      SEL_DIS:  rdata_o = en;
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o      = irq_q;
  assign wb_block_o = stat[WB_BIT];

  a_r7_irq_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == ($past(en[MASTER_BIT]) && ($past(stat[W-2:0] & en[W-2:0]) != '0))));

  a_r7_no_master_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en[MASTER_BIT] |=> !irq_o);

  a_r8_rise_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_rise |=> stat[RESUME_BIT]);

  a_r10_own_tied: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !HAS_SMI |-> !stat[OWN_BIT]);
endmodule

// File: tb/hc_irq_ctrl_tb.sv
module hc_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] evt = '0;
  logic        resume = 1'b0;
  logic [31:0] rdata, rdata2;
  logic        irq, irq2, wbb, wbb2;
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  hc_irq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .evt_i(evt), .resume_sig_i(resume), .irq_o(irq), .wb_block_o(wbb));

  hc_irq_ctrl #(.HAS_SMI(1'b0)) dut_nosmi_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata2), .evt_i(evt), .resume_sig_i(resume), .irq_o(irq2), .wb_block_o(wbb2));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse(input logic [31:0] e);
    @(negedge clk); evt = e;
    @(negedge clk); evt = '0;
  endtask

  task automatic resume_edge();
    @(negedge clk); resume = 1'b1;
    @(negedge clk); resume = 1'b0;
  endtask

  initial begin
    #(20ns * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, v); chk("R1 status reset", v, 32'h0);
    rd(2'd1, v); chk("R1 enable reset", v, 32'h0);
    chk("R1 irq reset", {31'b0, irq}, 32'h0);

    // R2: ignored positions, including event bit 3
    pulse(32'h0010_0088);
    rd(2'd0, v); chk("R2 ignored positions", v, 32'h0);

    // R3: write zero, write one, no software set
    pulse(32'h0000_0005);
    wr(2'd0, 32'h0);
    rd(2'd0, v); chk("R3 write zero keeps", v, 32'h5);
    wr(2'd0, 32'h1);
    rd(2'd0, v); chk("R3 write one clears", v, 32'h4);
    wr(2'd0, 32'h0000_0060);
    rd(2'd0, v); chk("R3 no software set", v, 32'h4);

    // R4: collision and hold
    wr(2'd0, 32'hFFFF_FFFF);
    @(negedge clk); evt = 32'h4; wr_en = 1'b1; addr = 2'd0; wdata = 32'h4;
    @(negedge clk); evt = '0; wr_en = 1'b0; wdata = '0;
    rd(2'd0, v); chk("R4 set wins", v, 32'h4);
    repeat (5) @(negedge clk);
    rd(2'd0, v); chk("R4 holds", v, 32'h4);
    wr(2'd0, 32'hFFFF_FFFF);

    // R5 / R6
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, v); chk("R5 enable set mask", v, 32'hC000_007F);
    wr(2'd1, 32'h0);
    rd(2'd1, v); chk("R5 write zero ignored", v, 32'hC000_007F);
    rd(2'd2, v); chk("R6 disable reads enable", v, 32'hC000_007F);
    wr(2'd2, 32'h8000_0001);
    rd(2'd1, v); chk("R6 disable clears", v, 32'h4000_007E);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, v); chk("R6 addr 3 reads zero", v, 32'h0);
    rd(2'd1, v); chk("R6 addr 3 write ignored", v, 32'h4000_007E);

    // R7: irq falls after status cleared
    wr(2'd1, 32'h8000_0000);
    pulse(32'h0000_0004);
    @(negedge clk);
    chk("R7 irq rises", {31'b0, irq}, 32'h1);
    wr(2'd0, 32'h4);
    @(negedge clk);
    chk("R7 irq falls", {31'b0, irq}, 32'h0);

    // sweep: position x enable x master
    for (int i = 0; i < 8; i++) begin
      for (int en = 0; en < 2; en++) begin
        for (int m = 0; m < 2; m++) begin
          int pos;
          pos = (i < 7) ? i : 30;
          wr(2'd2, 32'hFFFF_FFFF);
          wr(2'd0, 32'hFFFF_FFFF);
          if (pos == 3) resume_edge();
          else          pulse(32'h1 << pos);
          rd(2'd0, v); chk((pos == 3) ? "R8 resume edge sets" : "R2 event sets", v, 32'h1 << pos);
          chk("R9 wb block", {31'b0, wbb}, (pos == 1) ? 32'h1 : 32'h0);
          if (en == 1) wr(2'd1, 32'h1 << pos);
          if (m == 1)  wr(2'd1, 32'h8000_0000);
          @(negedge clk);
          chk("R7 irq gating", {31'b0, irq}, 32'((en == 1) && (m == 1)));
        end
      end
    end

    // R8: held level does not set again
    wr(2'd0, 32'hFFFF_FFFF);
    @(negedge clk); resume = 1'b1;
    @(negedge clk);
    rd(2'd0, v); chk("R8 rise sets", v, 32'h8);
    wr(2'd0, 32'h8);
    repeat (4) @(negedge clk);
    rd(2'd0, v); chk("R8 held level no reset", v, 32'h0);
    resume = 1'b0;

    // R9: block drops on clear
    pulse(32'h2);
    chk("R9 block set", {31'b0, wbb}, 32'h1);
    wr(2'd0, 32'h2);
    chk("R9 block cleared", {31'b0, wbb}, 32'h0);

    // R10
    wr(2'd0, 32'hFFFF_FFFF);
    pulse(32'h4000_0000);
    addr = 2'd0; #1;
    chk("R10 smi present", rdata, 32'h4000_0000);
    chk("R10 smi absent tied", rdata2, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule